// File: doc/BRIEF.md
# Master/Slave SPI Control Port

This block is the serial command port through which an external microcontroller exchanges bytes with the signal processor. Each transfer is full duplex. One 8-bit character leaves on one data line while another arrives on the other line. A single serial clock times both the shifting and the sampling. The port runs as bus master or as bus slave. In master mode it generates the serial clock from the system clock, drives an active-low select line and drives the MOSI pin. In slave mode it follows an external clock and select line and drives the MISO pin only while it is selected. Clock polarity and phase are fixed: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first.

The transmit side has a single buffer. A write from the core loads the shift register directly. In master mode that write also starts the transfer. The receive side has two buffers. A completed byte is copied into a read buffer, and the shift register is then free for the next byte. Status flags report an unread byte, a byte lost to overrun, and a write that arrived while a transfer was in progress.

Top module: `spi_ctrl_port`

## Requirements
- R1: In master mode each transfer shifts the written byte out on `mosi_out` MSB first while 8 bits are sampled from `miso_in` on rising edges of `sck_out`, and the received byte is assembled MSB first.
- R2: In master mode `sck_out` idles low, and its period is 2*(`half_div`+1) system clock cycles.
- R3: In master mode a write while idle starts a transfer; `ss_n_out` and `busy` indicate the transfer (low and high respectively) from the cycle after the write until the last falling clock edge.
- R4: In master mode `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. In slave mode `sck_oe` and `mosi_oe` are 0, and `miso_oe` is 1 only while `ss_n_in` is low.
- R5: In slave mode clock edges are ignored while `ss_n_in` is high. Deselecting in the middle of a byte discards the partial byte, and the next selection starts again at bit 7.
- R6: In slave mode a byte written while deselected appears on `miso_out` MSB first, one bit per clock cycle of `sck_in`, and each bit is valid before the rising edge that samples it.
- R7: A completed byte is copied to `rx_data` and `rx_full` is set to 1; a one-cycle `rx_rd` pulse clears `rx_full`.
- R8: If a byte completes while `rx_full` is 1 and no read occurs in the same cycle, `overrun` is set to 1 and `rx_data` keeps the unread byte. A read clears `overrun`.
- R9: A write while `busy` is 1 is ignored (the byte in transfer is unchanged) and sets `wcol` to 1; the next accepted write clears `wcol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = master mode, 0 = slave mode (change only while idle) |
| half_div | input | DIV_W | Master clock half period minus one, in system cycles |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_rd | input | 1 | Read strobe for the read buffer |
| rx_data | output | 8 | Read buffer contents |
| rx_full | output | 1 | Read buffer holds an unread byte |
| overrun | output | 1 | A byte was dropped because the buffer was full |
| wcol | output | 1 | A write was ignored because a transfer was in progress |
| busy | output | 1 | Transfer in progress (master) or port selected (slave) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| ss_n_out | output | 1 | Active-low select driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| ss_n_in | input | 1 | Active-low select received in slave mode |
| mosi_in | input | 1 | MOSI pin input (slave data in) |
| mosi_out | output | 1 | MOSI pin output (master data out) |
| mosi_oe | output | 1 | Output enable for MOSI |
| miso_in | input | 1 | MISO pin input (master data in) |
| miso_out | output | 1 | MISO pin output (slave data out) |
| miso_oe | output | 1 | Output enable for MISO |

## Verification
The assertions check the following on every cycle: the read buffer sets its full flag after each completion, an overrun keeps the stored byte, a write during a transfer raises the collision flag, the master clock stays low while idle, and an accepted master write asserts the select line. Other behaviour only the bench scenarios can show. These are the bit order on both data lines in both modes, the exact clock period for each divider value, and the recovery after a select line is released in the middle of a byte. They also include the check that a colliding write leaves the byte in transfer unchanged, which the bench confirms by reading back the far end's copy.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int DW = 8;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] sr;
        logic          bit_in;
        logic [CW-1:0] cnt;
        logic          wcol;
        logic          sck_prev;
    } core_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int            W      = 3,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             sck_d, sck_q;
    logic             strobe;

    always_comb begin
        strobe = run && (cnt_q == half_div);
        rise   = strobe && !sck_q;
        fall   = strobe && sck_q;
        cnt_d  = cnt_q;
        sck_d  = sck_q;
        if (!run) begin
            cnt_d = '0;
            sck_d = 1'b0;
        end else if (strobe) begin
            cnt_d = '0;
            sck_d = !sck_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sck_q <= sck_d;
        end
    end

    assign sck = sck_q;

    // R2: the clock returns low once the run request drops
    p_sck_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/spi_rxbuf.sv
module spi_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] byte_in,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          ovr
);
    logic [DW-1:0] data_d, data_q;
    logic          full_d, full_q;
    logic          ovr_d, ovr_q;

    always_comb begin
        data_d = data_q;
        full_d = full_q;
        ovr_d  = ovr_q;
        if (done) begin
            if (full_q && !rd) begin
                ovr_d = 1'b1;
            end else begin
                data_d = byte_in;
                full_d = 1'b1;
                ovr_d  = 1'b0;
            end
        end else if (rd) begin
            full_d = 1'b0;
            ovr_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            full_q <= full_d;
            ovr_q  <= ovr_d;
        end
    end

    assign data = data_q;
    assign full = full_q;
    assign ovr  = ovr_q;

    // R7: every completed byte leaves the buffer marked full
    p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full);

    // R8: an overrun keeps the unread byte and raises the flag
    p_ovr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd) |=> (ovr && data == $past(data)));
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [DIV_W-1:0] half_div,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_wr,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_data,
    output logic             rx_full,
    output logic             overrun,
    output logic             wcol,
    output logic             busy,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             ss_n_out,
    input  logic             sck_in,
    input  logic             ss_n_in,
    input  logic             mosi_in,
    output logic             mosi_out,
    output logic             mosi_oe,
    input  logic             miso_in,
    output logic             miso_out,
    output logic             miso_oe
);
    core_t         q, d;
    logic          sck_s, ss_s, mosi_s;
    logic          m_sck, m_rise, m_fall;
    logic          sel, rise, fall, in_bit, rx_done;
    logic [DW-1:0] rx_byte;

    spi_sync #(.W(3), .STAGES(2), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, ss_n_in, mosi_in}),
        .q     ({sck_s, ss_s, mosi_s})
    );

    spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.run),
        .half_div (half_div),
        .sck      (m_sck),
        .rise     (m_rise),
        .fall     (m_fall)
    );

    always_comb begin
        sel     = !master_en && !ss_s;
        rise    = master_en ? m_rise : (sel && sck_s && !q.sck_prev);
        fall    = master_en ? m_fall : (sel && !sck_s && q.sck_prev);
        in_bit  = master_en ? miso_in : mosi_s;
        busy    = master_en ? q.run : sel;
        rx_byte = {q.sr[DW-2:0], in_bit};
        rx_done = 1'b0;

        d          = q;
        d.sck_prev = sck_s;

        if (tx_wr) begin
            if (busy) begin
                d.wcol = 1'b1;
            end else begin
                d.sr   = tx_data;
                d.wcol = 1'b0;
                if (master_en) begin
                    d.run = 1'b1;
                    d.cnt = '0;
                end
            end
        end

        if (!master_en && !sel) d.cnt = '0;

        if (rise) begin
            d.bit_in = in_bit;
            if (q.cnt == CW'(DW - 1)) begin
                rx_done = 1'b1;
                d.cnt   = master_en ? q.cnt + 1'b1 : '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (fall) begin
            d.sr = {q.sr[DW-2:0], q.bit_in};
            if (master_en && q.cnt == CW'(DW)) begin
                d.run = 1'b0;
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_rxbuf #(.DW(DW)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (rx_done),
        .byte_in (rx_byte),
        .rd      (rx_rd),
        .data    (rx_data),
        .full    (rx_full),
        .ovr     (overrun)
    );

    assign wcol     = q.wcol;
    assign sck_out  = m_sck;
    assign sck_oe   = master_en;
    assign ss_n_out = !(master_en && q.run);
    assign mosi_out = q.sr[DW-1];
    assign mosi_oe  = master_en;
    assign miso_out = q.sr[DW-1];
    assign miso_oe  = sel;

    // R9: a write that meets an active transfer raises the collision flag
    p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> wcol);

    // R3: an accepted master write selects the far device next cycle
    p_start_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && tx_wr && !busy) |=> !ss_n_out);

    // R2: the master clock never leaves idle without a transfer
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !q.run) |-> !sck_out);
endmodule

// File: tb/tb_spi_ctrl_port.sv
module tb_spi_ctrl_port;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             master_en = 1'b1;
    logic [DIV_W-1:0] half_div = 8'd1;
    logic [7:0]       tx_data = '0;
    logic             tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_full, overrun, wcol, busy;
    logic             sck_out, sck_oe, ss_n_out;
    logic             sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;
    logic             mosi_out, mosi_oe, miso_in, miso_out, miso_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = !clk;

    spi_ctrl_port #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .half_div(half_div),
        .tx_data(tx_data), .tx_wr(tx_wr), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .wcol(wcol), .busy(busy),
        .sck_out(sck_out), .sck_oe(sck_oe), .ss_n_out(ss_n_out),
        .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    // far-end device model for master mode
    logic [7:0] far_tx = '0, far_sh = '0, far_rx = '0;
    always @(negedge ss_n_out) far_sh = far_tx;
    always @(posedge sck_out) begin
        far_rx = {far_rx[6:0], mosi_out};
        far_sh = far_sh << 1;
    end
    assign miso_in = far_sh[7];

    // stimulus table: {master mode, byte written to port, far-end byte}
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'hA5, 8'h3C}, {1'b1, 8'h00, 8'hFF}, {1'b1, 8'h81, 8'h7E},
        {1'b0, 8'hC3, 8'h5A}, {1'b0, 8'hFF, 8'h01}, {1'b0, 8'h12, 8'hED}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic m_xfer(input logic [7:0] b);
        wr(b);
        wait_idle();
    endtask

    task automatic s_bit(input logic b, output logic got);
        mosi_in = b;
        repeat (8) @(negedge clk);
        got = miso_out;
        sck_in = 1'b1;
        repeat (8) @(negedge clk);
        sck_in = 1'b0;
    endtask

    task automatic s_xfer(input logic [7:0] b, output logic [7:0] got);
        ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) s_bit(b[i], got[i]);
        repeat (8) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       g;
        realtime    t1, t2;

        repeat (3) @(negedge clk);
        // reset state (R3, R7, R8, R9, R2)
        chk(rx_full == 0 && overrun == 0 && wcol == 0, "R7 reset flags", {rx_full, overrun, wcol}, 0);
        chk(busy == 0 && ss_n_out == 1 && sck_out == 0, "R3 reset idle", {busy, ss_n_out, sck_out}, 3'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table-driven transfers
        for (int v = 0; v < NV; v++) begin
            master_en = VEC[v][16];
            repeat (4) @(negedge clk);
            if (VEC[v][16]) begin
                far_tx = VEC[v][7:0];
                m_xfer(VEC[v][15:8]);
                chk(far_rx == VEC[v][15:8], "R1 master out", far_rx, VEC[v][15:8]);
                chk(rx_data == VEC[v][7:0], "R1 master in", rx_data, VEC[v][7:0]);
            end else begin
                wr(VEC[v][15:8]);
                s_xfer(VEC[v][7:0], got);
                chk(got == VEC[v][15:8], "R6 slave out", got, VEC[v][15:8]);
                chk(rx_data == VEC[v][7:0], "R6 slave in", rx_data, VEC[v][7:0]);
            end
            chk(rx_full == 1, "R7 full set", rx_full, 1);
            rd();
            chk(rx_full == 0, "R7 full cleared", rx_full, 0);
        end

        // R4 pin directions
        master_en = 1'b1; repeat (4) @(negedge clk);
        chk({sck_oe, mosi_oe, miso_oe} == 3'b110, "R4 master dirs", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        master_en = 1'b0; repeat (4) @(negedge clk);
        chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R4 slave idle dirs", {sck_oe, mosi_oe, miso_oe}, 0);
        ss_n_in = 1'b0; repeat (4) @(negedge clk);
        chk(miso_oe == 1, "R4 slave selected drives", miso_oe, 1);
        ss_n_in = 1'b1; repeat (4) @(negedge clk);

        // R5 clocks ignored while deselected
        for (int i = 0; i < 8; i++) begin
            mosi_in = 1'b1; repeat (6) @(negedge clk);
            sck_in = 1'b1; repeat (6) @(negedge clk); sck_in = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk(rx_full == 0, "R5 deselected clocks ignored", rx_full, 0);

        // R5 abort mid-byte then full byte
        ss_n_in = 1'b0; repeat (8) @(negedge clk);
        for (int i = 0; i < 3; i++) s_bit(1'b1, g);
        repeat (8) @(negedge clk); ss_n_in = 1'b1; repeat (8) @(negedge clk);
        chk(rx_full == 0, "R5 partial discarded", rx_full, 0);
        s_xfer(8'h81, got);
        chk(rx_full == 1 && rx_data == 8'h81, "R5 restart at bit 7", rx_data, 8'h81);
        rd();

        // R2 and R3 master clock period and select
        master_en = 1'b1; repeat (4) @(negedge clk);
        for (int h = 1; h <= 3; h += 2) begin
            half_div = 8'(h);
            far_tx = 8'h00;
            wr(8'h55);
            chk(ss_n_out == 0 && busy == 1, "R3 select during transfer", {ss_n_out, busy}, 2'b01);
            @(posedge sck_out); t1 = $realtime;
            @(posedge sck_out); t2 = $realtime;
            chk(int'((t2 - t1) / 20.0) == 2 * (h + 1), "R2 sck period", int'((t2 - t1) / 20.0), 2 * (h + 1));
            wait_idle();
            chk(ss_n_out == 1 && sck_out == 0, "R3 released after transfer", {ss_n_out, sck_out}, 2'b10);
            rd();
        end
        half_div = 8'd1;

        // R8 overrun keeps unread byte
        far_tx = 8'h11; m_xfer(8'h00);
        far_tx = 8'h22; m_xfer(8'h00);
        chk(overrun == 1 && rx_data == 8'h11, "R8 overrun keeps byte", {overrun, rx_data}, {1'b1, 8'h11});
        rd();
        chk(overrun == 0 && rx_full == 0, "R8 read clears", {overrun, rx_full}, 0);

        // R9 write collision ignored
        far_tx = 8'h00;
        wr(8'h5A);
        repeat (3) @(negedge clk);
        wr(8'hFF);
        wait_idle();
        chk(wcol == 1, "R9 collision flagged", wcol, 1);
        chk(far_rx == 8'h5A, "R9 collided byte ignored", far_rx, 8'h5A);
        rd();
        wr(8'h33);
        chk(wcol == 0, "R9 accepted write clears", wcol, 0);
        wait_idle();
        chk(far_rx == 8'h33, "R1 after collision", far_rx, 8'h33);
        rd();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule